// File: doc/BRIEF.md
# Real-Time Clock Timekeeper with Update Sequencing

This block holds the calendar of a CMOS-style real-time clock: seconds, minutes, hours, day of week, day of month, month and two-digit year. A single-cycle enable, `tick`, arrives at the reference rate (32.768 kHz by default). The block counts these ticks to form a sub-second phase and advances the calendar once per second. A fixed number of ticks before each advance it raises an update-in-progress flag. It keeps that flag high for a further fixed number of ticks after the advance, so software polling the flag never reads a half-updated set of values.

Software reaches the block through a flat register port: a 4-bit index, write data, a write strobe and a combinational read-data bus. A control register selects BCD or binary presentation and 12-hour or 24-hour hours. It also carries a freeze bit that stops all updates while the clock is loaded, and an enable for a one-cycle update-finished interrupt. Values are kept internally in binary 24-hour form and converted at the port, so the format can change at any time without corrupting the count.

The update sequencer is a state machine with five states:
- `ST_FROZEN`: freeze set; phase held at zero.
- `ST_COUNT`: normal counting with the flag low.
- `ST_LEAD`: flag high, waiting for the rollover tick.
- `ST_APPLY`: one clock in which the calendar advances.
- `ST_HOLD`: flag still high after the advance.

It moves between them as follows:
- Setting the freeze bit takes any state to `ST_FROZEN`.
- Clearing the freeze bit takes `ST_FROZEN` to `ST_COUNT`.
- `ST_COUNT` goes to `ST_LEAD` on the tick that brings the phase to TICKS_PER_SEC−UIP_LEAD_TICKS.
- `ST_LEAD` goes to `ST_APPLY` on the tick that wraps the phase to zero.
- `ST_APPLY` always goes to `ST_HOLD` on the next clock.
- `ST_HOLD` goes to `ST_COUNT` on the tick that brings the phase to UIP_HOLD_TICKS, and that transition signals update-finished.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset the control register (index 0xB) reads 0x02, and the calendar reads 00:00:00, day of week 7, date 01/01, year 00. Status index 0xA reads 0x00, and `uip` and `upd_irq` are low.
- R2: The update-in-progress flag (status 0xA bit 7, and port `uip`) rises on the tick that brings the sub-second phase to TICKS_PER_SEC−UIP_LEAD_TICKS. The time registers do not change until one clock after the UIP_LEAD_TICKS-th tick that follows.
- R3: After the calendar advances, the flag stays high until the UIP_HOLD_TICKS-th tick after the rollover tick, then falls.
- R4: While control bit 7 (freeze) is set, the calendar does not advance and the flag is low. Clearing it restarts the phase at zero, so the next advance comes exactly TICKS_PER_SEC ticks later, and no skipped second is replayed.
- R5: Control bit 2 clear presents and accepts all time values as packed BCD; set, as plain binary.
- R6: Control bit 1 set gives 24-hour hours (0–23). Clear gives 12-hour hours (12, 1..11) with bit 7 of the hours register as PM, and PM toggles on the 11→12 step.
- R7: Seconds and minutes wrap 59→0 with carry, and hours wrap 23→0 with carry into the date.
- R8: Day of week counts 1..7 and wraps 7→1 at midnight.
- R9: Day of month wraps after 30 days in months 4, 6, 9 and 11, after 31 in other months, and after 29 in month 2 when the year is divisible by 4 (28 otherwise).
- R10: Month wraps 12→1 with carry into the year, and the year wraps 99→0.
- R11: When control bit 4 is set, `upd_irq` pulses for exactly one clock after each update finishes. When it is clear, `upd_irq` stays low.
- R12: The time fields sit at indices 0x0 sec, 0x2 min, 0x4 hour, 0x6 day of week, 0x7 date, 0x8 month and 0x9 year. Index 0xD reads 0x80 (contents valid). Writes to 0xA, 0xD or any unmapped index change nothing, and unmapped indices read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock enable at the reference rate |
| addr | input | 4 | Register index |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe for the indexed register |
| rdata | output | 8 | Read data for the indexed register (combinational) |
| uip | output | 1 | Update-in-progress flag |
| upd_irq | output | 1 | One-clock update-finished interrupt pulse |

## Verification
The bench builds the block with TICKS_PER_SEC=16, UIP_LEAD_TICKS=4 and UIP_HOLD_TICKS=2. With these values a whole second is 16 hand-driven ticks, so the exact tick on which the flag rises, the rollover tick and the hold release can each be observed one by one. The short second also brings the month-end, leap-year, year-wrap and 12-hour PM cases within a few hundred clocks. Freezing in the middle of the lead window then shows that the phase restarts and that no second is replayed.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [2:0] {
        ST_FROZEN,
        ST_COUNT,
        ST_LEAD,
        ST_APPLY,
        ST_HOLD
    } upd_state_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [4:0] hr;
        logic [2:0] dow;
        logic [4:0] dom;
        logic [3:0] mon;
        logic [6:0] yr;
    } tod_t;

    localparam int NFIELD = 7;
    localparam int F_SEC = 0;
    localparam int F_MIN = 1;
    localparam int F_HR  = 2;
    localparam int F_DOW = 3;
    localparam int F_DOM = 4;
    localparam int F_MON = 5;
    localparam int F_YR  = 6;

    localparam logic [3:0] IX_SEC = 4'h0;
    localparam logic [3:0] IX_MIN = 4'h2;
    localparam logic [3:0] IX_HR  = 4'h4;
    localparam logic [3:0] IX_DOW = 4'h6;
    localparam logic [3:0] IX_DOM = 4'h7;
    localparam logic [3:0] IX_MON = 4'h8;
    localparam logic [3:0] IX_YR  = 4'h9;
    localparam logic [3:0] IX_STA = 4'hA;
    localparam logic [3:0] IX_CTL = 4'hB;
    localparam logic [3:0] IX_VLD = 4'hD;

    localparam int CB_FREEZE = 7;
    localparam int CB_UIE    = 4;
    localparam int CB_BIN    = 2;
    localparam int CB_H24    = 1;
    localparam logic [7:0] CTL_RESET = 8'h02;

    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        logic [6:0] t;
        logic [6:0] o;
        t = v / 7'd10;
        o = v - t * 7'd10;
        return {t[3:0], o[3:0]};
    endfunction

    function automatic logic [6:0] from_bcd(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] yr);
        logic [4:0] d;
        case (mon)
            4'd2:                       d = (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:    d = 5'd30;
            default:                    d = 5'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_phase_fsm.sv
module rtc_phase_fsm
    import rtc_pkg::*;
#(
    parameter int TPS  = 32768,
    parameter int LEAD = 8,
    parameter int HOLD = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic freeze,
    output logic uip,
    output logic apply,
    output logic done
);

    localparam int PW = (TPS > 1) ? $clog2(TPS) : 1;
    localparam logic [PW-1:0] PH_LAST    = PW'(TPS - 1);
    localparam logic [PW-1:0] PH_LEAD_AT = PW'(TPS - LEAD - 1);
    localparam logic [PW-1:0] PH_HOLD_AT = PW'(HOLD - 1);

    upd_state_e st_q;
    upd_state_e st_d;
    logic [PW-1:0] ph_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_COUNT;
        else        st_q <= st_d;
    end

    // next-state selection
    always_comb begin
        st_d = st_q;
        if (freeze) begin
            st_d = ST_FROZEN;
        end else begin
            unique case (st_q)
                ST_FROZEN: st_d = ST_COUNT;
                ST_COUNT:  if (tick && ph_q == PH_LEAD_AT) st_d = ST_LEAD;
                ST_LEAD:   if (tick && ph_q == PH_LAST)    st_d = ST_APPLY;
                ST_APPLY:  st_d = ST_HOLD;
                ST_HOLD:   if (tick && ph_q == PH_HOLD_AT) st_d = ST_COUNT;
                default:   st_d = ST_FROZEN;
            endcase
        end
    end

    // sub-second phase
    always_ff @(posedge clk) begin
        if (!rst_n)                          ph_q <= '0;
        else if (freeze || st_q == ST_FROZEN) ph_q <= '0;
        else if (tick)                       ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    end

    // outputs
    always_comb begin
        uip   = (st_q == ST_LEAD) || (st_q == ST_APPLY) || (st_q == ST_HOLD);
        apply = (st_q == ST_APPLY) && !freeze;
        done  = (st_q == ST_HOLD) && tick && (ph_q == PH_HOLD_AT) && !freeze;
    end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  logic [NFIELD-1:0] wr_sel,
    input  tod_t              wr_val,
    output tod_t              tod
);

    tod_t tod_q;
    tod_t nxt;
    logic [4:0] mdays;

    assign mdays = month_days(tod_q.mon, tod_q.yr);

    always_comb begin
        nxt = tod_q;
        if (tod_q.sec >= 7'd59) begin
            nxt.sec = '0;
            if (tod_q.min >= 7'd59) begin
                nxt.min = '0;
                if (tod_q.hr >= 5'd23) begin
                    nxt.hr  = '0;
                    nxt.dow = (tod_q.dow >= 3'd7 || tod_q.dow == 3'd0) ? 3'd1 : tod_q.dow + 3'd1;
                    if (tod_q.dom >= mdays) begin
                        nxt.dom = 5'd1;
                        if (tod_q.mon >= 4'd12) begin
                            nxt.mon = 4'd1;
                            nxt.yr  = (tod_q.yr >= 7'd99) ? 7'd0 : tod_q.yr + 7'd1;
                        end else begin
                            nxt.mon = tod_q.mon + 4'd1;
                        end
                    end else begin
                        nxt.dom = tod_q.dom + 5'd1;
                    end
                end else begin
                    nxt.hr = tod_q.hr + 5'd1;
                end
            end else begin
                nxt.min = tod_q.min + 7'd1;
            end
        end else begin
            nxt.sec = tod_q.sec + 7'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tod_q <= '{sec: 7'd0, min: 7'd0, hr: 5'd0, dow: 3'd7, dom: 5'd1, mon: 4'd1, yr: 7'd0};
        end else begin
            if (wr_sel[F_SEC])      tod_q.sec <= wr_val.sec;
            else if (apply)         tod_q.sec <= nxt.sec;
            if (wr_sel[F_MIN])      tod_q.min <= wr_val.min;
            else if (apply)         tod_q.min <= nxt.min;
            if (wr_sel[F_HR])       tod_q.hr  <= wr_val.hr;
            else if (apply)         tod_q.hr  <= nxt.hr;
            if (wr_sel[F_DOW])      tod_q.dow <= wr_val.dow;
            else if (apply)         tod_q.dow <= nxt.dow;
            if (wr_sel[F_DOM])      tod_q.dom <= wr_val.dom;
            else if (apply)         tod_q.dom <= nxt.dom;
            if (wr_sel[F_MON])      tod_q.mon <= wr_val.mon;
            else if (apply)         tod_q.mon <= nxt.mon;
            if (wr_sel[F_YR])       tod_q.yr  <= wr_val.yr;
            else if (apply)         tod_q.yr  <= nxt.yr;
        end
    end

    assign tod = tod_q;

endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  tod_t              tod,
    input  logic              uip,
    output logic [7:0]        ctl,
    output logic [NFIELD-1:0] wr_sel,
    output tod_t              wr_val,
    output logic [7:0]        rdata
);

    logic bin_mode;
    logic h24_mode;
    logic [6:0] wdec;
    logic [6:0] h12_in;
    logic [6:0] h24_in;
    logic [6:0] hr_bin;
    logic [6:0] h12_out;
    logic       pm_out;
    logic [7:0] h12_enc;

    assign bin_mode = ctl[CB_BIN];
    assign h24_mode = ctl[CB_H24];

    function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
        return bin ? {1'b0, v} : to_bcd(v);
    endfunction

    function automatic logic [6:0] dec(input logic [7:0] w, input logic bin);
        return bin ? w[6:0] : from_bcd(w);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n)                      ctl <= CTL_RESET;
        else if (wr_en && addr == IX_CTL) ctl <= wdata;
    end

    // write decode and conversion to binary 24-hour form
    always_comb begin
        wdec   = dec(wdata, bin_mode);
        h12_in = dec({1'b0, wdata[6:0]}, bin_mode);
        if (h24_mode)               h24_in = wdec;
        else if (h12_in == 7'd12)   h24_in = wdata[7] ? 7'd12 : 7'd0;
        else                        h24_in = wdata[7] ? h12_in + 7'd12 : h12_in;

        wr_val.sec = wdec;
        wr_val.min = wdec;
        wr_val.hr  = h24_in[4:0];
        wr_val.dow = wdec[2:0];
        wr_val.dom = wdec[4:0];
        wr_val.mon = wdec[3:0];
        wr_val.yr  = wdec;

        wr_sel         = '0;
        wr_sel[F_SEC]  = wr_en && (addr == IX_SEC);
        wr_sel[F_MIN]  = wr_en && (addr == IX_MIN);
        wr_sel[F_HR]   = wr_en && (addr == IX_HR);
        wr_sel[F_DOW]  = wr_en && (addr == IX_DOW);
        wr_sel[F_DOM]  = wr_en && (addr == IX_DOM);
        wr_sel[F_MON]  = wr_en && (addr == IX_MON);
        wr_sel[F_YR]   = wr_en && (addr == IX_YR);
    end

    // read side hour presentation
    always_comb begin
        hr_bin = 7'(tod.hr);
        pm_out = (hr_bin >= 7'd12);
        if (hr_bin == 7'd0)       h12_out = 7'd12;
        else if (hr_bin > 7'd12)  h12_out = hr_bin - 7'd12;
        else                      h12_out = hr_bin;
        h12_enc = enc(h12_out, bin_mode);
    end

    always_comb begin
        case (addr)
            IX_SEC:  rdata = enc(tod.sec, bin_mode);
            IX_MIN:  rdata = enc(tod.min, bin_mode);
            IX_HR:   rdata = h24_mode ? enc(hr_bin, bin_mode) : {pm_out, h12_enc[6:0]};
            IX_DOW:  rdata = enc(7'(tod.dow), bin_mode);
            IX_DOM:  rdata = enc(7'(tod.dom), bin_mode);
            IX_MON:  rdata = enc(7'(tod.mon), bin_mode);
            IX_YR:   rdata = enc(tod.yr, bin_mode);
            IX_STA:  rdata = {uip, 7'd0};
            IX_CTL:  rdata = ctl;
            IX_VLD:  rdata = 8'h80;
            default: rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC  = 32768,
    parameter int UIP_LEAD_TICKS = 8,
    parameter int UIP_HOLD_TICKS = 65
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    input  logic       wr_en,
    output logic [7:0] rdata,
    output logic       uip,
    output logic       upd_irq
);

    logic [7:0]        ctl;
    logic [NFIELD-1:0] wr_sel;
    tod_t              wr_val;
    tod_t              tod_q;
    logic              apply;
    logic              done;
    logic              freeze_bit;
    logic              irq_q;
    logic [6:0]        sec_b;

    assign freeze_bit = ctl[CB_FREEZE];
    assign sec_b      = tod_q.sec;

    rtc_phase_fsm #(
        .TPS  (TICKS_PER_SEC),
        .LEAD (UIP_LEAD_TICKS),
        .HOLD (UIP_HOLD_TICKS)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .freeze (freeze_bit),
        .uip    (uip),
        .apply  (apply),
        .done   (done)
    );

    rtc_calendar u_cal (
        .clk    (clk),
        .rst_n  (rst_n),
        .apply  (apply),
        .wr_sel (wr_sel),
        .wr_val (wr_val),
        .tod    (tod_q)
    );

    rtc_regport u_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wdata  (wdata),
        .wr_en  (wr_en),
        .tod    (tod_q),
        .uip    (uip),
        .ctl    (ctl),
        .wr_sel (wr_sel),
        .wr_val (wr_val),
        .rdata  (rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= done && ctl[CB_UIE];
    end

    assign upd_irq = irq_q;

endmodule

// File: rtl/rtc_timekeeper_chk.sv
module rtc_timekeeper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       wr_en,
    input logic       uip,
    input logic       upd_irq,
    input logic       freeze,
    input logic [6:0] sec_b
);

    // R2: the flag only rises on a reference tick
    assert_uip_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip) |-> $past(tick));

    // R2: a seconds change not caused by a write happens under the flag
    assert_sec_moves_under_uip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sec_b) && !$past(wr_en)) |-> $past(uip));

    // R4: freeze forces the flag low on the following clock
    assert_frozen_no_uip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> !uip);

    // R4: no advance while frozen
    assert_frozen_sec_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !wr_en) |=> $stable(sec_b));

    // R11: interrupt follows an update window
    assert_irq_after_uip_R11: assert property (@(posedge clk) disable iff (!rst_n)
        upd_irq |-> $past(uip));

    // R11: interrupt is a single-clock pulse
    assert_irq_one_clock_R11: assert property (@(posedge clk) disable iff (!rst_n)
        upd_irq |=> !upd_irq);

endmodule

bind rtc_timekeeper rtc_timekeeper_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .uip     (uip),
    .upd_irq (upd_irq),
    .freeze  (freeze_bit),
    .sec_b   (sec_b)
);

// File: tb/sim_rtc_timekeeper.sv
`timescale 1ns/1ps
module sim_rtc_timekeeper;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] rdata;
    logic       uip;
    logic       upd_irq;

    int n_chk = 0;
    int n_fail = 0;
    int irq_cnt = 0;

    typedef struct {
        logic [3:0] a;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    rtc_timekeeper #(
        .TICKS_PER_SEC  (16),
        .UIP_LEAD_TICKS (4),
        .UIP_HOLD_TICKS (2)
    ) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .addr    (addr),
        .wdata   (wdata),
        .wr_en   (wr_en),
        .rdata   (rdata),
        .uip     (uip),
        .upd_irq (upd_irq)
    );

    // monitor: pops expected reads and compares away from the clock edge
    always @(negedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_chk++;
            if (rdata !== it.exp) begin
                n_fail++;
                $display("FAIL %s: index %h actual %h expected %h", it.tag, it.a, rdata, it.exp);
            end
        end
    end

    always @(negedge clk) if (rst_n && upd_irq) irq_cnt++;

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a;
        sb.push_back('{a, e, tag});
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] fmt, input logic [7:0] s, input logic [7:0] m,
                        input logic [7:0] h, input logic [7:0] dw, input logic [7:0] dm,
                        input logic [7:0] mo, input logic [7:0] y);
        wr(4'hB, fmt | 8'h80);
        wr(4'h0, s); wr(4'h2, m); wr(4'h4, h); wr(4'h6, dw);
        wr(4'h7, dm); wr(4'h8, mo); wr(4'h9, y);
        wr(4'hB, fmt);
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #600000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'hB, 8'h02, "R1 ctl");
        rd(4'h0, 8'h00, "R1 sec");
        rd(4'h4, 8'h00, "R1 hour");
        rd(4'h6, 8'h07, "R1 dow");
        rd(4'h7, 8'h01, "R1 date");
        rd(4'h8, 8'h01, "R1 month");
        rd(4'h9, 8'h00, "R1 year");
        rd(4'hA, 8'h00, "R1 status");
        drain();
        check(int'(uip), 0, "R1 uip");
        check(int'(upd_irq), 0, "R1 irq");

        // R4 freeze holds the clock; R7 R8 R9 leap step, BCD (R5)
        wr(4'hB, 8'h82);
        wr(4'h0, 8'h59); wr(4'h2, 8'h59); wr(4'h4, 8'h23); wr(4'h6, 8'h07);
        wr(4'h7, 8'h28); wr(4'h8, 8'h02); wr(4'h9, 8'h04);
        pulse(20);
        rd(4'h0, 8'h59, "R4 frozen sec");
        rd(4'hA, 8'h00, "R4 frozen status");
        wr(4'hB, 8'h02);
        pulse(11);
        rd(4'hA, 8'h00, "R2 flag before lead");
        pulse(1);
        rd(4'hA, 8'h80, "R2 flag raised");
        rd(4'h0, 8'h59, "R2 sec held in lead");
        pulse(3);
        rd(4'h0, 8'h59, "R2 sec held at last tick");
        pulse(1);
        rd(4'h0, 8'h00, "R2 R7 sec rolled");
        rd(4'hA, 8'h80, "R3 flag after rollover");
        pulse(1);
        rd(4'hA, 8'h80, "R3 flag in hold");
        pulse(1);
        rd(4'hA, 8'h00, "R3 flag released");
        rd(4'h2, 8'h00, "R7 min");
        rd(4'h4, 8'h00, "R7 hour");
        rd(4'h6, 8'h01, "R8 dow wrap");
        rd(4'h7, 8'h29, "R9 leap day");
        rd(4'h8, 8'h02, "R9 month kept");
        rd(4'h9, 8'h04, "R5 year bcd");

        // R9 leap February end
        load(8'h02, 8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h04);
        pulse(18);
        rd(4'h7, 8'h01, "R9 leap feb end date");
        rd(4'h8, 8'h03, "R9 leap feb end month");
        rd(4'h6, 8'h04, "R8 dow step");

        // R9 non-leap February
        load(8'h02, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h05);
        pulse(18);
        rd(4'h7, 8'h01, "R9 feb28 date");
        rd(4'h8, 8'h03, "R9 feb28 month");

        // R9 30-day month
        load(8'h02, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10);
        pulse(18);
        rd(4'h7, 8'h01, "R9 apr30 date");
        rd(4'h8, 8'h05, "R9 apr30 month");

        // R9 31-day month does not wrap at 30
        load(8'h02, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h01, 8'h10);
        pulse(18);
        rd(4'h7, 8'h31, "R9 jan30 date");
        rd(4'h8, 8'h01, "R9 jan30 month");

        // R10 year wrap
        load(8'h02, 8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
        pulse(18);
        rd(4'h7, 8'h01, "R10 date");
        rd(4'h8, 8'h01, "R10 month wrap");
        rd(4'h9, 8'h00, "R10 year wrap");

        // R5 binary presentation
        load(8'h06, 8'h3B, 8'h0A, 8'h09, 8'h02, 8'h05, 8'h06, 8'h0A);
        pulse(18);
        rd(4'h0, 8'h00, "R5 bin sec");
        rd(4'h2, 8'h0B, "R5 bin min");
        rd(4'h4, 8'h09, "R5 bin hour");

        // R6 twelve-hour mode
        load(8'h00, 8'h59, 8'h59, 8'h11, 8'h02, 8'h05, 8'h06, 8'h10);
        pulse(18);
        rd(4'h4, 8'h92, "R6 11am to 12pm");
        wr(4'hB, 8'h02);
        rd(4'h4, 8'h12, "R6 noon in 24h");
        load(8'h00, 8'h59, 8'h59, 8'h91, 8'h02, 8'h05, 8'h06, 8'h10);
        pulse(18);
        rd(4'h4, 8'h12, "R6 11pm to 12am");
        rd(4'h6, 8'h03, "R6 R8 day advance");
        rd(4'h7, 8'h06, "R6 date advance");
        wr(4'hB, 8'h02);
        rd(4'h4, 8'h00, "R6 midnight in 24h");

        // R11 interrupt
        drain();
        check(irq_cnt, 0, "R11 no irq while disabled");
        load(8'h12, 8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        pulse(18);
        drain();
        check(irq_cnt, 1, "R11 one irq pulse");
        wr(4'hB, 8'h02);

        // R4 freeze inside the lead window, no replay
        load(8'h02, 8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        pulse(13);
        rd(4'hA, 8'h80, "R4 in lead");
        wr(4'hB, 8'h82);
        rd(4'hA, 8'h00, "R4 flag dropped on freeze");
        rd(4'h0, 8'h10, "R4 no advance on freeze");
        wr(4'hB, 8'h02);
        pulse(15);
        rd(4'h0, 8'h10, "R4 phase restarted");
        rd(4'hA, 8'h80, "R4 lead again");
        pulse(1);
        rd(4'h0, 8'h11, "R4 single advance");
        pulse(2);

        // R12 address map
        wr(4'h1, 8'h55);
        rd(4'h1, 8'h00, "R12 unmapped");
        wr(4'hA, 8'hFF);
        rd(4'hA, 8'h00, "R12 status read-only");
        wr(4'hD, 8'h00);
        rd(4'hD, 8'h80, "R12 valid bit");
        rd(4'h0, 8'h11, "R12 sec untouched");
        rd(4'hB, 8'h02, "R12 ctl untouched");

        drain();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule